// File: doc/BRIEF.md
# Clock Bank Divider and Gating Controller

This block takes a fast core clock, which stands in for an oscillator output, and a reference clock. It drives four banks of two clock outputs. Each output bit is a registered level that the core clock updates. A free-running phase counter supplies the waveforms:

- The undivided waveform changes level on every core cycle.
- The divide-by-two and divide-by-four waveforms come from the higher counter bits.

The first two banks always carry the undivided waveform. Bank 3 can divide. Bank 4 can divide or drive an inverted copy.

The counter is held cleared after reset until the selected edge of the reference arrives. The edge-polarity input picks which edge, so every bank starts in a known phase relative to the reference.

A stop input parks the outputs at a defined level without runt pulses. Bank 2 keeps running so that it can close an external feedback loop. A three-level test input has two further uses:

- It can bypass the core path and copy the reference to every output.
- Together with the stop input, it selects a sub-mode in which each bank is disabled individually by its own select code.

Top module: `clkbank_top`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, every output bit is driven low at that edge.
- R2: After reset the phase counter stays cleared, and the outputs hold still, until the selected edge of the synchronized reference: rising when `pol_sel`=1, falling when `pol_sel`=0. The opposite edge has no effect.
- R3: Banks 1 and 2 always follow the undivided waveform, which changes level on every `clk` cycle.
- R4: Bank 3 select code: 2'b00 divides by 2, 2'b10 divides by 4, and 2'b01 or 2'b11 pass the undivided waveform.
- R5: Bank 4 select code: 2'b00 divides by 2, 2'b10 gives the inverse of the undivided waveform, and 2'b01 or 2'b11 pass the undivided waveform.
- R6: Every level change of a divided waveform coincides with a falling edge of the undivided waveform, so all banks stay phase aligned.
- R7: With `test_code`=2'b00 and `stop_req`=1, banks 1, 3 and 4 park and bank 2 keeps running. The parked level is low, except that bank 4 in inverted mode parks at the value of `pol_sel`.
- R8: A bank's gate opens or closes only while the bank's waveform sits at its parked level. After a restart, the first pulse therefore has its full width: 4 cycles for divide-by-4.
- R9: With `test_code` at MID and `stop_req`=1, the core path runs. Any bank whose select code is 2'b00 is held low, and every other bank runs.
- R10: With `test_code`=2'b10 (HIGH), or MID with `stop_req`=0, every output bit copies the synchronized reference. The latency is two synchronizer stages plus the output register.
- R11: Three-level codes decode as 2'b00=LOW, 2'b01=MID and 2'b10=HIGH, and 2'b11 acts as MID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast core clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Reference clock, asynchronous, synchronized inside the block |
| pol_sel | input | 1 | 1 aligns to the rising reference edge, 0 to the falling edge |
| stop_req | input | 1 | 1 requests that the outputs park |
| test_code | input | 2 | Three-level test mode code |
| sel_b1 | input | 2 | Bank 1 code, used only for the test sub-mode disable |
| sel_b2 | input | 2 | Bank 2 code, used only for the test sub-mode disable |
| sel_b3 | input | 2 | Bank 3 divider code |
| sel_b4 | input | 2 | Bank 4 divider or invert code |
| clk_b1 | output | OUTS_PER_BANK | Bank 1 outputs |
| clk_b2 | output | OUTS_PER_BANK | Bank 2 outputs, the feedback bank |
| clk_b3 | output | OUTS_PER_BANK | Bank 3 outputs |
| clk_b4 | output | OUTS_PER_BANK | Bank 4 outputs |

## Verification
Four rules are checked on every cycle:
- the reset clearing of the outputs;
- the alignment of divided waveform edges to falling edges of the undivided waveform;
- the rule that a gate changes state only while its output sits at the parked level;
- the copying of the reference in bypass.

The bench scenarios are what show the following:
- the divide ratios for each select code, which are counted as toggles over fixed windows;
- the wait for the chosen reference edge;
- the parked levels, including the polarity-dependent level of inverted bank 4;
- the full width of the first pulse after a restart;
- the per-bank disables of the test sub-mode, including the 2'b11 code.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } tri_lvl_t;

  typedef enum logic [1:0] {
    SRC_DIV1 = 2'b00,
    SRC_DIV2 = 2'b01,
    SRC_DIV4 = 2'b10,
    SRC_INV  = 2'b11
  } bank_src_t;

  // Pre-encoded three-level pin: the unused code folds onto MID (R11)
  function automatic tri_lvl_t decode_tri(input logic [1:0] code);
    case (code)
      2'b00:   return LVL_LOW;
      2'b10:   return LVL_HIGH;
      default: return LVL_MID;
    endcase
  endfunction

endpackage

// File: rtl/clkbank_phase.sv
module clkbank_phase #(
  parameter int CNT_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_clk,
  input  logic             pol_sel,
  output logic             ref_lvl,
  output logic             aligned,
  output logic [CNT_W-1:0] phase
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ref_d;
  logic                   edge_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      ref_d  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ref_clk};
      ref_d  <= sync_q[SYNC_STAGES-1];
    end
  end

  assign ref_lvl  = sync_q[SYNC_STAGES-1];
  assign edge_hit = pol_sel ? (ref_lvl & ~ref_d) : (~ref_lvl & ref_d);

  // Counter held at zero until the chosen reference edge, then free-running
  always_ff @(posedge clk) begin
    if (rst) begin
      aligned <= 1'b0;
      phase   <= '0;
    end else if (!aligned) begin
      phase <= '0;
      if (edge_hit) aligned <= 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/clkbank_gate.sv
module clkbank_gate #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw_lvl,
  input  logic             stop_lvl,
  input  logic             want_run,
  input  logic             bypass,
  input  logic             ref_lvl,
  output logic             gate_en,
  output logic [WIDTH-1:0] q
);

  // The gate changes state only while the waveform rests at the parked level
  always_ff @(posedge clk) begin
    if (rst)                      gate_en <= 1'b0;
    else if (raw_lvl == stop_lvl) gate_en <= want_run;
  end

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (bypass)  q <= {WIDTH{ref_lvl}};
    else if (gate_en) q <= {WIDTH{raw_lvl}};
    else              q <= {WIDTH{stop_lvl}};
  end

endmodule

// File: rtl/clkbank_top.sv
module clkbank_top
  import clkbank_pkg::*;
#(
  parameter int OUTS_PER_BANK = 2,
  parameter int MAX_DIV       = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ref_clk,
  input  logic                     pol_sel,
  input  logic                     stop_req,
  input  logic [1:0]               test_code,
  input  logic [1:0]               sel_b1,
  input  logic [1:0]               sel_b2,
  input  logic [1:0]               sel_b3,
  input  logic [1:0]               sel_b4,
  output logic [OUTS_PER_BANK-1:0] clk_b1,
  output logic [OUTS_PER_BANK-1:0] clk_b2,
  output logic [OUTS_PER_BANK-1:0] clk_b3,
  output logic [OUTS_PER_BANK-1:0] clk_b4
);

  localparam int NUM_BANKS = 4;
  localparam int CNT_W     = $clog2(MAX_DIV) + 1;
  localparam int FB_BANK   = 1;

  logic [CNT_W-1:0]     phase;
  logic                 aligned;
  logic                 ref_lvl;
  tri_lvl_t             test_lvl;
  logic                 sub_mode;
  logic                 bypass_mode;
  tri_lvl_t             sel_lvl [NUM_BANKS];
  bank_src_t            src     [NUM_BANKS];
  logic [NUM_BANKS-1:0] raw;
  logic [NUM_BANKS-1:0] want_run;
  logic [NUM_BANKS-1:0] stop_lvl;
  logic [NUM_BANKS-1:0] gate_en;
  logic [OUTS_PER_BANK-1:0] bank_q [NUM_BANKS];

  clkbank_phase #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_phase (
    .clk    (clk),
    .rst    (rst),
    .ref_clk(ref_clk),
    .pol_sel(pol_sel),
    .ref_lvl(ref_lvl),
    .aligned(aligned),
    .phase  (phase)
  );

  assign test_lvl    = decode_tri(test_code);
  assign sub_mode    = (test_lvl == LVL_MID) && stop_req;
  assign bypass_mode = (test_lvl != LVL_LOW) && !sub_mode;

  assign sel_lvl[0] = decode_tri(sel_b1);
  assign sel_lvl[1] = decode_tri(sel_b2);
  assign sel_lvl[2] = decode_tri(sel_b3);
  assign sel_lvl[3] = decode_tri(sel_b4);

  always_comb begin
    src[0] = SRC_DIV1;
    src[1] = SRC_DIV1;
    case (sel_lvl[2])
      LVL_LOW:  src[2] = SRC_DIV2;
      LVL_HIGH: src[2] = SRC_DIV4;
      default:  src[2] = SRC_DIV1;
    endcase
    case (sel_lvl[3])
      LVL_LOW:  src[3] = SRC_DIV2;
      LVL_HIGH: src[3] = SRC_INV;
      default:  src[3] = SRC_DIV1;
    endcase
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb begin
      case (src[b])
        SRC_DIV2: raw[b] = phase[1];
        SRC_DIV4: raw[b] = phase[CNT_W-1];
        SRC_INV:  raw[b] = ~phase[0];
        default:  raw[b] = phase[0];
      endcase
      if (sub_mode)         want_run[b] = (sel_lvl[b] != LVL_LOW);
      else if (b == FB_BANK) want_run[b] = 1'b1;
      else                  want_run[b] = !stop_req;
      stop_lvl[b] = (src[b] == SRC_INV) ? pol_sel : 1'b0;
    end

    clkbank_gate #(
      .WIDTH(OUTS_PER_BANK)
    ) u_gate (
      .clk     (clk),
      .rst     (rst),
      .raw_lvl (raw[b]),
      .stop_lvl(stop_lvl[b]),
      .want_run(want_run[b]),
      .bypass  (bypass_mode),
      .ref_lvl (ref_lvl),
      .gate_en (gate_en[b]),
      .q       (bank_q[b])
    );
  end

  assign clk_b1 = bank_q[0];
  assign clk_b2 = bank_q[1];
  assign clk_b3 = bank_q[2];
  assign clk_b4 = bank_q[3];

endmodule

// File: rtl/clkbank_chk.sv
module clkbank_chk #(
  parameter int OUTS_PER_BANK = 2,
  parameter int CNT_W         = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic [CNT_W-1:0]         div_lvl,
  input logic [3:0]               gate_en,
  input logic [3:0]               stop_lvl,
  input logic                     bypass,
  input logic                     ref_lvl,
  input logic [OUTS_PER_BANK-1:0] q_b1,
  input logic [OUTS_PER_BANK-1:0] q_b2,
  input logic [OUTS_PER_BANK-1:0] q_b3,
  input logic [OUTS_PER_BANK-1:0] q_b4
);

  logic       rst_q;
  logic [3:0] q_lsb;

  assign q_lsb = {q_b4[0], q_b3[0], q_b2[0], q_b1[0]};

  always_ff @(posedge clk) rst_q <= rst;

  // p_reset_low_r1
  always @(posedge clk) begin
    if (rst_q) begin
      p_reset_low_r1: assert ((q_b1 | q_b2 | q_b3 | q_b4) == '0)
        else $error("R1: outputs not cleared by reset");
    end
  end

  p_div2_align_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (div_lvl[1] != $past(div_lvl[1])))
      |-> ($past(div_lvl[0]) && !div_lvl[0]));

  p_div4_align_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (div_lvl[CNT_W-1] != $past(div_lvl[CNT_W-1])))
      |-> (!div_lvl[0] && !div_lvl[1]));

  for (genvar b = 0; b < 4; b++) begin : g_gate_chk
    p_gate_clean_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(bypass) && (gate_en[b] != $past(gate_en[b])))
        |-> (q_lsb[b] == $past(stop_lvl[b])));
  end

  p_bypass_copy_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bypass))
      |-> ((q_b1 == {OUTS_PER_BANK{$past(ref_lvl)}}) &&
           (q_b2 == {OUTS_PER_BANK{$past(ref_lvl)}}) &&
           (q_b3 == {OUTS_PER_BANK{$past(ref_lvl)}}) &&
           (q_b4 == {OUTS_PER_BANK{$past(ref_lvl)}})));

endmodule

bind clkbank_top clkbank_chk #(
  .OUTS_PER_BANK(OUTS_PER_BANK),
  .CNT_W        (CNT_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .div_lvl (phase),
  .gate_en (gate_en),
  .stop_lvl(stop_lvl),
  .bypass  (bypass_mode),
  .ref_lvl (ref_lvl),
  .q_b1    (clk_b1),
  .q_b2    (clk_b2),
  .q_b3    (clk_b3),
  .q_b4    (clk_b4)
);

// File: tb/clkbank_top_tb.sv
module clkbank_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 2;

  logic         clk = 1'b0;
  logic         rst;
  logic         ref_clk, pol_sel, stop_req;
  logic [1:0]   test_code, sel_b1, sel_b2, sel_b3, sel_b4;
  logic [W-1:0] clk_b1, clk_b2, clk_b3, clk_b4;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done     = 1'b0;
  int  t1, t2, t3, t4, same14;
  bit  lo1, lo3, lo4, hi4;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkbank_top #(.OUTS_PER_BANK(W)) u_dut (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .pol_sel(pol_sel),
    .stop_req(stop_req), .test_code(test_code),
    .sel_b1(sel_b1), .sel_b2(sel_b2), .sel_b3(sel_b3), .sel_b4(sel_b4),
    .clk_b1(clk_b1), .clk_b2(clk_b2), .clk_b3(clk_b3), .clk_b4(clk_b4)
  );

  typedef struct packed {
    logic [1:0] s3;
    logic [1:0] s4;
    int         tog3;
    int         tog4;
    bit         inv4;
  } vec_t;

  // Toggle counts over a 32-cycle window: 32 for /1, 16 for /2, 8 for /4
  localparam vec_t VECS [5] = '{
    '{2'b00, 2'b00, 16, 16, 1'b0},
    '{2'b10, 2'b01,  8, 32, 1'b0},
    '{2'b01, 2'b10, 32, 32, 1'b1},
    '{2'b11, 2'b11, 32, 32, 1'b0},
    '{2'b10, 2'b00,  8, 16, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sample at falling edges and count level changes of each bank
  task automatic window(input int n);
    logic p1, p2, p3, p4;
    t1 = 0; t2 = 0; t3 = 0; t4 = 0; same14 = 0;
    lo1 = 1; lo3 = 1; lo4 = 1; hi4 = 1;
    @(negedge clk);
    p1 = clk_b1[0]; p2 = clk_b2[0]; p3 = clk_b3[0]; p4 = clk_b4[0];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_b1[0] != p1) t1++;
      if (clk_b2[0] != p2) t2++;
      if (clk_b3[0] != p3) t3++;
      if (clk_b4[0] != p4) t4++;
      if (clk_b1[0] == clk_b4[0]) same14++;
      if (clk_b1 != '0) lo1 = 0;
      if (clk_b3 != '0) lo3 = 0;
      if (clk_b4 != '0) lo4 = 0;
      if (clk_b4 != '1) hi4 = 0;
      p1 = clk_b1[0]; p2 = clk_b2[0]; p3 = clk_b3[0]; p4 = clk_b4[0];
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cycles(5);
    chk((clk_b1 | clk_b2 | clk_b3 | clk_b4) == '0, "R1 reset low",
        int'({clk_b1, clk_b2, clk_b3, clk_b4}), 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int hi_len;
    ref_clk = 0; pol_sel = 1; stop_req = 0; test_code = 2'b00;
    sel_b1 = 2'b01; sel_b2 = 2'b01; sel_b3 = 2'b01; sel_b4 = 2'b01;
    @(negedge clk);
    do_reset();

    // R2: rising-edge alignment; outputs hold until the edge arrives
    window(20);
    chk(t1 == 0 && lo1, "R2 static before rising edge", t1, 0);
    ref_clk = 1'b1;
    cycles(10);
    window(16);
    chk(t1 == 16, "R2 R3 bank1 runs after rising edge", t1, 16);
    chk(t2 == 16, "R3 bank2 undivided", t2, 16);

    // R2: falling-edge alignment ignores a rising edge
    pol_sel = 1'b0; ref_clk = 1'b0;
    do_reset();
    ref_clk = 1'b1;
    cycles(10);
    window(20);
    chk(t1 == 0, "R2 rising edge ignored when pol_sel=0", t1, 0);
    ref_clk = 1'b0;
    cycles(10);
    window(16);
    chk(t1 == 16, "R2 falling edge starts counter", t1, 16);
    pol_sel = 1'b1;

    // R4 R5 R6: divider table
    foreach (VECS[k]) begin
      sel_b3 = VECS[k].s3; sel_b4 = VECS[k].s4;
      cycles(8);
      window(32);
      chk(t1 == 32, "R3 bank1 undivided", t1, 32);
      chk(t3 == VECS[k].tog3, "R4 bank3 divide", t3, VECS[k].tog3);
      chk(t4 == VECS[k].tog4, "R5 bank4 select", t4, VECS[k].tog4);
      if (VECS[k].inv4) chk(same14 == 0, "R5 R6 bank4 inverted", same14, 0);
      else if (VECS[k].tog4 == 32) chk(same14 == 32, "R6 bank4 in phase", same14, 32);
    end

    // R7: stop parks banks 1,3,4 low, bank 2 keeps running
    sel_b3 = 2'b10; sel_b4 = 2'b01;
    stop_req = 1'b1;
    cycles(8);
    window(16);
    chk(lo1 && t1 == 0, "R7 bank1 parked low", t1, 0);
    chk(lo3 && t3 == 0, "R7 bank3 parked low", t3, 0);
    chk(lo4 && t4 == 0, "R7 bank4 parked low", t4, 0);
    chk(t2 == 16, "R7 bank2 keeps running", t2, 16);
    sel_b4 = 2'b10;
    cycles(4);
    window(8);
    chk(hi4, "R7 inverted bank4 parks high with pol_sel=1", int'(clk_b4), 3);
    pol_sel = 1'b0;
    cycles(4);
    window(8);
    chk(lo4, "R7 inverted bank4 parks low with pol_sel=0", int'(clk_b4), 0);
    pol_sel = 1'b1; sel_b4 = 2'b01;
    cycles(2);

    // R8: restart gives a full-width first pulse on divide-by-4
    stop_req = 1'b0;
    for (int i = 0; i < 16 && clk_b3[0] == 1'b0; i++) @(negedge clk);
    hi_len = 0;
    while (clk_b3[0] == 1'b1 && hi_len < 10) begin
      hi_len++;
      @(negedge clk);
    end
    chk(hi_len == 4, "R8 first pulse after restart", hi_len, 4);

    // R10: bypass copies the reference
    test_code = 2'b10;
    ref_clk = 1'b1; cycles(5);
    chk({clk_b1, clk_b2, clk_b3, clk_b4} == '1, "R10 HIGH bypass ref=1",
        int'({clk_b1, clk_b2, clk_b3, clk_b4}), 255);
    ref_clk = 1'b0; cycles(5);
    chk({clk_b1, clk_b2, clk_b3, clk_b4} == '0, "R10 HIGH bypass ref=0",
        int'({clk_b1, clk_b2, clk_b3, clk_b4}), 0);
    test_code = 2'b01;
    ref_clk = 1'b1; cycles(5);
    chk({clk_b1, clk_b2, clk_b3, clk_b4} == '1, "R10 MID bypass without stop",
        int'({clk_b1, clk_b2, clk_b3, clk_b4}), 255);
    ref_clk = 1'b0; cycles(5);

    // R9: test sub-mode disables LL banks only
    sel_b1 = 2'b00; sel_b2 = 2'b01; sel_b3 = 2'b00; sel_b4 = 2'b01;
    stop_req = 1'b1;
    cycles(8);
    window(32);
    chk(lo1 && t1 == 0, "R9 LL bank1 disabled", t1, 0);
    chk(lo3 && t3 == 0, "R9 LL bank3 disabled", t3, 0);
    chk(t2 == 32, "R9 bank2 runs", t2, 32);
    chk(t4 == 32, "R9 bank4 runs despite stop", t4, 32);

    // R11: code 2'b11 behaves as MID
    test_code = 2'b11;
    cycles(4);
    window(32);
    chk(lo1 && t1 == 0, "R11 test 2'b11 as MID bank1 off", t1, 0);
    chk(t2 == 32, "R11 test 2'b11 as MID bank2 runs", t2, 32);
    sel_b2 = 2'b00;
    cycles(6);
    window(16);
    chk(t2 == 0, "R9 LL bank2 disabled", t2, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule